// File: doc/BRIEF.md
# Memory Wait-State Controller

This block sits between a synchronous processor bus and a memory that cannot answer within a single bus clock. When the processor raises a request, the block captures the address and the transfer direction. It then holds the memory select and the matching read or write enable active for a stretched access, and returns a one-clock ready pulse in the final cycle of that access. The processor can sample the data at that point, because the memory has had the full stretched time to respond.

The length of an access is the sum of two software-loaded settings. The first is a base length of one to four clocks, which covers both single-clock and multi-clock bus timings. The second is a number of wait states from zero to seven, where each wait state adds exactly one clock. A wait count is chosen from a timing budget. For example, take a 50 ns clock and a 10 ns loss to buffering and decoding. An 80 ns memory on a one-clock base then needs one wait state: the access grows to 100 ns and leaves 90 ns for the memory. New settings apply from the next access that starts, and never to an access already running.

Top module: `memws_ctrl`

## Requirements
- R1: While reset is low, and in the first cycle after it, ready is low and the select, read and write enables (all active low) are high.
- R2: For an access accepted at a clock edge, with length L = base + wait, ready stays low for L-1 cycles and is high for exactly one cycle, the L-th cycle after acceptance.
- R3: The memory select is low in every one of the L cycles of an access and high in the cycle after the ready cycle.
- R4: A request with rd_wr = 1 is a read and drives only the read enable low; rd_wr = 0 is a write and drives only the write enable low; outside an access both enables are high.
- R5: The address and direction are captured at acceptance and held constant for the whole access, even when the inputs change.
- R6: A request that is raised while an access runs, including during its ready cycle, is ignored. A request that is still held after the ready cycle is accepted one idle cycle later.
- R7: A configuration load (cfg_we high) stores base = cfg_base + 1 (2-bit code 0..3) and wait = cfg_wait (3 bits). The stored values apply from the next accepted access. A load in the same cycle as an acceptance, or in the middle of an access, leaves that access at its old length.
- R8: After reset the stored base code and wait count are both 0, so the first access lasts one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req | input | 1 | Access request strobe, sampled when idle |
| rd_wr | input | 1 | Direction: 1 read, 0 write |
| addr | input | ADDR_W | Access address |
| cfg_we | input | 1 | Load strobe for the timing settings |
| cfg_base | input | BASE_W | Base length code (length = code + 1) |
| cfg_wait | input | WAIT_W | Number of wait states |
| ready | output | 1 | One-cycle completion pulse to the processor |
| mem_cs_n | output | 1 | Memory select, active low |
| mem_rd_n | output | 1 | Memory read enable, active low |
| mem_wr_n | output | 1 | Memory write enable, active low |
| mem_addr | output | ADDR_W | Captured address to memory |

## Verification
Two pairs of events can land on the same clock edge. The first pair is a configuration load and the acceptance of a request. The bench raises cfg_we and req together, and requires that the new access keeps the old length while the following access takes the new one. The second pair is the ready cycle and a request that is still pending. The bench holds req high through a whole access and changes the address in the middle of it. It then requires that the captured address does not move, that exactly one idle cycle follows ready, and that the next access starts with the new address.

// File: rtl/memws_pkg.sv
// Shared types for the memory wait-state controller.
// Assumes: read is encoded as 1 on the direction input.
package memws_pkg;
    typedef enum logic {
        DIR_WRITE = 1'b0,
        DIR_READ  = 1'b1
    } dir_e;
endpackage

// File: rtl/memws_cfg.sv
// Timing settings register: base length code and wait-state count.
// Assumes: a load is a single-cycle strobe; the values are read by the
// sequencer only when an access is accepted.
module memws_cfg #(
    parameter int BASE_W = 2,
    parameter int WAIT_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [BASE_W-1:0] base_in,
    input  logic [WAIT_W-1:0] wait_in,
    output logic [BASE_W-1:0] base_code,
    output logic [WAIT_W-1:0] wait_cnt
);
    // Hold the settings; clear both fields on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_code <= '0;
            wait_cnt  <= '0;
        end else if (load) begin
            base_code <= base_in;
            wait_cnt  <= wait_in;
        end
    end
endmodule

// File: rtl/memws_seq.sv
// Access sequencer: accepts a request when idle, latches the address and
// direction, and counts down the stretched access.
// Assumes: len_m1 is the access length minus one, valid at acceptance.
module memws_seq
    import memws_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int LEN_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              rd_wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [LEN_W-1:0]  len_m1,
    output logic              busy,
    output logic              last,
    output dir_e              dir,
    output logic [ADDR_W-1:0] addr_q
);
    logic [LEN_W-1:0] remain;

    // Start, count down and end the access; ignore requests while busy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy   <= 1'b0;
            remain <= '0;
            dir    <= DIR_READ;
            addr_q <= '0;
        end else if (!busy) begin
            if (req) begin
                busy   <= 1'b1;
                remain <= len_m1;
                dir    <= dir_e'(rd_wr);
                addr_q <= addr;
            end
        end else if (remain == '0) begin
            busy <= 1'b0;
        end else begin
            remain <= remain - 1'b1;
        end
    end

    // Flag the final cycle of the access.
    always_comb last = busy && (remain == '0);
endmodule

// File: rtl/memws_strobe.sv
// Strobe decode: turns the sequencer state into the active-low memory
// enables and the ready pulse.
// Assumes: busy and last come straight from registers, so no glitches.
module memws_strobe
    import memws_pkg::*;
(
    input  logic busy,
    input  logic last,
    input  dir_e dir,
    output logic ready,
    output logic cs_n,
    output logic rd_n,
    output logic wr_n
);
    // Decode the enables from the state and the latched direction.
    always_comb begin
        ready = last;
        cs_n  = !busy;
        rd_n  = !(busy && (dir == DIR_READ));
        wr_n  = !(busy && (dir == DIR_WRITE));
    end
endmodule

// File: rtl/memws_ctrl.sv
// Memory wait-state controller top. Stretches each access to
// (base code + 1 + wait) clocks and returns a one-cycle ready pulse.
// Assumes: single bus master; the settings change only through cfg_we.
module memws_ctrl
    import memws_pkg::*;
#(
    parameter int ADDR_W   = 20,
    parameter int BASE_MAX = 4,
    parameter int WAIT_W   = 3,
    localparam int BASE_W  = $clog2(BASE_MAX),
    localparam int LEN_W   = $clog2(BASE_MAX + (1 << WAIT_W))
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              rd_wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic              cfg_we,
    input  logic [BASE_W-1:0] cfg_base,
    input  logic [WAIT_W-1:0] cfg_wait,
    output logic              ready,
    output logic              mem_cs_n,
    output logic              mem_rd_n,
    output logic              mem_wr_n,
    output logic [ADDR_W-1:0] mem_addr
);
    logic [BASE_W-1:0] base_code;
    logic [WAIT_W-1:0] wait_cnt;
    logic [LEN_W-1:0]  len_m1;
    logic              busy;
    logic              last;
    dir_e              dir;

    memws_cfg #(.BASE_W(BASE_W), .WAIT_W(WAIT_W)) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (cfg_we),
        .base_in   (cfg_base),
        .wait_in   (cfg_wait),
        .base_code (base_code),
        .wait_cnt  (wait_cnt)
    );

    // Length minus one equals base code plus wait count.
    always_comb len_m1 = LEN_W'(base_code) + LEN_W'(wait_cnt);

    memws_seq #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .req    (req),
        .rd_wr  (rd_wr),
        .addr   (addr),
        .len_m1 (len_m1),
        .busy   (busy),
        .last   (last),
        .dir    (dir),
        .addr_q (mem_addr)
    );

    memws_strobe u_strobe (
        .busy  (busy),
        .last  (last),
        .dir   (dir),
        .ready (ready),
        .cs_n  (mem_cs_n),
        .rd_n  (mem_rd_n),
        .wr_n  (mem_wr_n)
    );
endmodule

// File: rtl/memws_ctrl_chk.sv
// Property checker for memws_ctrl, attached by bind below.
module memws_ctrl_chk #(
    parameter int ADDR_W = 20
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ready,
    input logic              mem_cs_n,
    input logic              mem_rd_n,
    input logic              mem_wr_n,
    input logic [ADDR_W-1:0] mem_addr
);
    // R1
    rst_idle_chk: assert property (@(posedge clk)
        !rst_n |=> (mem_cs_n && mem_rd_n && mem_wr_n && !ready));
    // R2
    ready_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ready |=> !ready);
    // R3
    ready_in_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> !mem_cs_n);
    // R3
    select_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_cs_n && !ready) |=> !mem_cs_n);
    // R4
    enables_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_cs_n |-> (mem_rd_n && mem_wr_n));
    // R4
    one_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_cs_n |-> (mem_rd_n != mem_wr_n));
    // R5
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_cs_n && !ready) |=> ($stable(mem_addr) && $stable(mem_rd_n)));
    // R6
    idle_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ready |=> mem_cs_n);
endmodule

bind memws_ctrl memws_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ready    (ready),
    .mem_cs_n (mem_cs_n),
    .mem_rd_n (mem_rd_n),
    .mem_wr_n (mem_wr_n),
    .mem_addr (mem_addr)
);

// File: tb/memws_ctrl_test.sv
`timescale 1ns/1ps
module memws_ctrl_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0;
    logic        rd_wr = 1'b1;
    logic [19:0] addr = '0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_base = '0;
    logic [2:0]  cfg_wait = '0;
    logic        ready, mem_cs_n, mem_rd_n, mem_wr_n;
    logic [19:0] mem_addr;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    memws_ctrl uut (
        .clk(clk), .rst_n(rst_n), .req(req), .rd_wr(rd_wr), .addr(addr),
        .cfg_we(cfg_we), .cfg_base(cfg_base), .cfg_wait(cfg_wait),
        .ready(ready), .mem_cs_n(mem_cs_n), .mem_rd_n(mem_rd_n),
        .mem_wr_n(mem_wr_n), .mem_addr(mem_addr)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Load settings; called at a negedge, returns at the next negedge.
    task automatic load_cfg(input logic [1:0] b, input logic [2:0] w);
        cfg_we = 1'b1; cfg_base = b; cfg_wait = w;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // Called just after an acceptance edge. Follows L cycles, then checks
    // the idle cycle after ready. Returns at that idle negedge.
    task automatic follow(input int len, input bit rd, input logic [19:0] a,
                          input string tag, input bit hold,
                          input bit mid_cfg, input logic [1:0] nb, input logic [2:0] nw);
        int  ready_at = 0;
        bit  cover_ok = 1, dir_ok = 1, addr_ok = 1;
        @(negedge clk);
        if (!hold) req = 1'b0;
        addr = ~a; rd_wr = ~rd;
        cfg_we = mid_cfg; cfg_base = nb; cfg_wait = nw;
        for (int i = 1; i <= len; i++) begin
            if (mem_cs_n) cover_ok = 0;
            if (rd ? (mem_rd_n || !mem_wr_n) : (mem_wr_n || !mem_rd_n)) dir_ok = 0;
            if (mem_addr != a) addr_ok = 0;
            if (ready) ready_at = (ready_at == 0) ? i : -1;
            @(negedge clk);
            cfg_we = 1'b0;
        end
        rd_wr = rd;
        check(ready_at == len, {tag, " R2 ready cycle"}, ready_at, len);
        check(cover_ok, {tag, " R3 select covers access"}, cover_ok, 1);
        check(dir_ok, {tag, " R4 direction enable"}, dir_ok, 1);
        check(addr_ok, {tag, " R5 address held"}, addr_ok, 1);
        check(mem_cs_n && !ready && mem_rd_n && mem_wr_n,
              {tag, " R3 idle after ready"}, mem_cs_n, 1);
    endtask

    // Raise a request at a negedge and let it be accepted.
    task automatic start(input bit rd, input logic [19:0] a);
        req = 1'b1; rd_wr = rd; addr = a;
        @(posedge clk);
    endtask

    task automatic t_reset;
        req = 1'b1;
        repeat (3) @(negedge clk);
        check(mem_cs_n && mem_rd_n && mem_wr_n && !ready, "R1 outputs in reset", mem_cs_n, 1);
        req = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        check(mem_cs_n && !ready, "R1 idle after reset", mem_cs_n, 1);
        start(1'b1, 20'h12345);
        follow(1, 1'b1, 20'h12345, "R8 default length", 0, 0, 2'd0, 3'd0);
    endtask

    task automatic t_sweep;
        for (int b = 0; b < 4; b++) begin
            for (int w = 0; w < 8; w++) begin
                logic [19:0] a = 20'(b * 37 + w * 1031 + 5);
                bit rd = ((b + w) % 2) == 0;
                load_cfg(2'(b), 3'(w));
                start(rd, a);
                follow(b + 1 + w, rd, a, $sformatf("sweep b%0d w%0d", b + 1, w), 0, 0, 2'd0, 3'd0);
            end
        end
    endtask

    task automatic t_ignore;
        load_cfg(2'd3, 3'd3);
        start(1'b0, 20'hA5A5A);
        follow(7, 1'b0, 20'hA5A5A, "R6 held request", 1, 0, 2'd0, 3'd0);
        // Request still high: accepted at the coming edge with the new address.
        @(posedge clk);
        check(1'b1, "R6 accept", 0, 0);
        follow(7, 1'b0, ~20'hA5A5A, "R6 follow-on access", 0, 0, 2'd0, 3'd0);
    endtask

    task automatic t_cfg_same_cycle;
        load_cfg(2'd0, 3'd0);
        cfg_we = 1'b1; cfg_base = 2'd2; cfg_wait = 3'd5;
        start(1'b1, 20'h00F0F);
        follow(1, 1'b1, 20'h00F0F, "R7 load with acceptance", 0, 0, 2'd0, 3'd0);
        start(1'b0, 20'h0F0F0);
        follow(8, 1'b0, 20'h0F0F0, "R7 next access new length", 0, 0, 2'd0, 3'd0);
    endtask

    task automatic t_cfg_mid;
        load_cfg(2'd1, 3'd1);
        start(1'b1, 20'h33333);
        follow(3, 1'b1, 20'h33333, "R7 load mid access", 0, 1, 2'd3, 3'd7);
        start(1'b1, 20'h44444);
        follow(11, 1'b1, 20'h44444, "R7 after mid load", 0, 0, 2'd0, 3'd0);
    endtask

    initial begin
        #(5.0 * 150000);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_sweep();
        t_ignore();
        t_cfg_same_cycle();
        t_cfg_mid();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule